// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Encoder

This block gathers up to fifteen groups of sixteen general-purpose input lines into one interrupt. Each line passes through a two-flop synchroniser and is judged against a trigger selector. A selector is four bits wide and is shared by four adjacent lines; it picks level-low, level-high, falling, rising or both-edge detection. A detected event sets a sticky pending bit. A per-line mask bit keeps a pending line out of the interrupt and out of the service code, but it does not stop the line from latching.

Software sees three register spaces: trigger selectors, masks and pending bits. Each space packs two groups into one 32-bit word. Software clears a pending bit by writing 1 to it. An 8-bit service code names the lowest-numbered unmasked pending line as a group and pin pair, with the group counted from one. Software reads the code, handles and acknowledges that line, and reads again until the group field is zero. Group 1 holds two eight-pin banks: pin codes 0 to 7 belong to the first bank, and codes 8 to 15 belong to the second bank at pin minus 8.

Top module: `gpio_irq_svc`

## Requirements
- R1: While reset is held and on the first cycle after it, every mask bit reads 1, every pending bit reads 0, every trigger field reads 4 (rising edge), `irq_o` is 0 and `svc_o` is 0.
- R2: Line i maps to word i/32, bit i%32 of the mask space (`cfg_space`=1) and the pending space (`cfg_space`=2). Its trigger is the 4-bit field at bits 4*((i%32)/4)+3 down to 4*((i%32)/4) of word i/32 in the trigger space (`cfg_space`=0). `cfg_rdata` shows the word selected by `cfg_space`/`cfg_word`, and reads 0 for a word index beyond the last word.
- R3: Trigger codes are 0 level low, 1 level high, 2 falling, 4 rising and 6 both edges; any other code disables its four lines. A pin change driven between two clock edges sets its pending bit on the third rising edge after the change.
- R4: A line whose mask bit is 1 still latches its pending bit but affects neither `irq_o` nor `svc_o`.
- R5: A write to the pending space clears each bit written as 1 and leaves each bit written as 0 alone. A pending bit never clears without such a write. A write to the trigger or mask space replaces the selected word.
- R6: A hardware event that sets a pending bit in the same cycle as a write-1 clear to that bit leaves the bit set.
- R7: `svc_o[7:4]` holds (i/16)+1 and `svc_o[3:0]` holds i%16 for the reported line i. `svc_o` is 0 when no unmasked line is pending.
- R8: Among unmasked pending lines the lowest group wins, and within a group the lowest pin wins. The code follows the pending bits in the same cycle that a clear takes effect.
- R9: `irq_o` is 1 exactly when some unmasked pending bit is set.
- R10: A level-coded line whose pin holds the active level sets its pending bit again immediately after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_GROUPS*16 | Asynchronous input lines |
| cfg_we | input | 1 | Write strobe for the selected word |
| cfg_space | input | 2 | Register space: 0 trigger, 1 mask, 2 pending |
| cfg_word | input | WIDX | Word index within the space |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected word, combinational |
| irq_o | output | 1 | Combined interrupt |
| svc_o | output | 8 | Service code: group+1 in bits 7:4, pin in bits 3:0 |

## Verification
The bench watches priority when two lines in different groups fire together, and when two pins in one group fire together. An encoder that scans from the wrong end would report the later line. It also acknowledges a line on the exact edge where that line's event arrives; a design that lets the clear win would lose the event. Level-coded lines are cleared while the pin still holds its level, which exposes any design that treats them as edges. The bench also counts the edges from a pin change to the service code, so an extra or missing synchroniser stage shows up as an early or late code.

// File: rtl/gsvc_pkg.sv
// Shared constants and trigger decoding for the grouped GPIO interrupt encoder.
// Assumes 16 lines per group and 32-bit register words.
package gsvc_pkg;

    localparam int LINES_PER_GRP = 16;
    localparam int WORD_BITS     = 32;

    typedef enum logic [1:0] {
        SPC_TRIG = 2'd0,
        SPC_MASK = 2'd1,
        SPC_PEND = 2'd2,
        SPC_NONE = 2'd3
    } space_e;

    localparam logic [3:0] TRG_LOW  = 4'd0;
    localparam logic [3:0] TRG_HIGH = 4'd1;
    localparam logic [3:0] TRG_FALL = 4'd2;
    localparam logic [3:0] TRG_RISE = 4'd4;
    localparam logic [3:0] TRG_ANY  = 4'd6;

    // Decide whether a line is firing, given its trigger code and the
    // current and previous synchronised samples.
    function automatic logic line_hit(input logic [3:0] code,
                                      input logic now, input logic prev);
        case (code)
            TRG_LOW:  return !now;
            TRG_HIGH: return now;
            TRG_FALL: return prev && !now;
            TRG_RISE: return now && !prev;
            TRG_ANY:  return now != prev;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gsvc_sync.sv
// Two-flop synchroniser with one history stage per line.
// Assumes pins may change at any time; all stages reset to 0.
module gsvc_sync #(
    parameter int WIDTH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] now_q,
    output logic [WIDTH-1:0] prev_q
);

    logic [WIDTH-1:0] meta_q;

    // Shift each pin through the metastability stage, the stable stage and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

endmodule

// File: rtl/gsvc_regs.sv
// Trigger, mask and pending storage, with two groups packed per 32-bit word.
// Assumes one write per cycle; hardware sets override write-1 clears.
module gsvc_regs #(
    parameter  int NWORDS = 5,
    localparam int NB     = NWORDS * 32,
    localparam int WIDX   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      sel_space,
    input  logic [WIDX-1:0] sel_word,
    input  logic [31:0]     wr_data,
    input  logic [NB-1:0]   hit,
    output logic [NB-1:0]   trig_q,
    output logic [NB-1:0]   mask_q,
    output logic [NB-1:0]   pend_q,
    output logic [31:0]     rd_data
);
    import gsvc_pkg::*;

    logic [NB-1:0] clr_vec;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        logic        hit_word;
        logic [31:0] trig_w, mask_w, pend_w;

        assign hit_word = wr_en && (int'(sel_word) == w);
        assign clr_vec[w*32 +: 32] = (hit_word && sel_space == SPC_PEND) ? wr_data : 32'd0;

        // Hold one word of each space: software writes config, events set pending.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                trig_w <= {8{TRG_RISE}};
                mask_w <= '1;
                pend_w <= '0;
            end else begin
                if (hit_word && sel_space == SPC_TRIG) trig_w <= wr_data;
                if (hit_word && sel_space == SPC_MASK) mask_w <= wr_data;
                pend_w <= (pend_w & ~clr_vec[w*32 +: 32]) | hit[w*32 +: 32];
            end
        end

        assign trig_q[w*32 +: 32] = trig_w;
        assign mask_q[w*32 +: 32] = mask_w;
        assign pend_q[w*32 +: 32] = pend_w;
    end

    // Return the selected word of the selected space, zero when out of range.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (int'(sel_word) == w) begin
                case (sel_space)
                    SPC_TRIG: rd_data = trig_q[w*32 +: 32];
                    SPC_MASK: rd_data = mask_q[w*32 +: 32];
                    SPC_PEND: rd_data = pend_q[w*32 +: 32];
                    default:  rd_data = '0;
                endcase
            end
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_q == '1 && pend_q == '0)); // R1
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pend_q & $past(hit)) == $past(hit))); // R6
    AST_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_vec)) == '0)); // R5

endmodule

// File: rtl/gsvc_encode.sv
// Priority encoder from unmasked pending lines to the 8-bit service code.
// Assumes at most 15 groups so that group+1 fits in four bits.
module gsvc_encode #(
    parameter  int NGRP = 10,
    parameter  int NB   = 160,
    localparam int NL   = NGRP * 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] pend,
    input  logic [NB-1:0] mask,
    output logic [7:0]    svc,
    output logic          any_act
);

    logic [NL-1:0] act_l;
    logic [NL-1:0] sel_bit;
    int            idx;

    assign act_l   = pend[NL-1:0] & ~mask[NL-1:0];
    assign any_act = |act_l;

    // Scan from the top so that the lowest group and pin are written last.
    always_comb begin
        svc = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
            for (int p = 15; p >= 0; p--) begin
                if (act_l[g*16 + p]) svc = {4'(g + 1), 4'(p)};
            end
        end
    end

    // Turn the reported code back into a one-hot line position for checking.
    always_comb begin
        idx     = (int'(svc[7:4]) - 1) * 16 + int'(svc[3:0]);
        sel_bit = (svc[7:4] != 4'd0) ? (NL'(1) << idx) : '0;
    end

    AST_SVC_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (svc[7:4] != 4'd0) |-> ((act_l & sel_bit) != '0)); // R7
    AST_SVC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (svc[7:4] != 4'd0) |-> ((act_l & (sel_bit - NL'(1))) == '0)); // R8
    AST_SVC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (svc == 8'd0) |-> (act_l == '0)); // R7

endmodule

// File: rtl/gpio_irq_svc.sv
// Grouped GPIO interrupt controller: synchronises pins, detects per-line
// triggers, keeps mask and pending words, and encodes one service code.
// Assumes register access through a single word port with a combinational read.
module gpio_irq_svc #(
    parameter  int NUM_GROUPS = 10,
    localparam int NUM_LINES  = NUM_GROUPS * 16,
    localparam int NWORDS     = (NUM_GROUPS + 1) / 2,
    localparam int NB         = NWORDS * 32,
    localparam int WIDX       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pin_in,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_space,
    input  logic [WIDX-1:0]      cfg_word,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic                 irq_o,
    output logic [7:0]           svc_o
);
    import gsvc_pkg::*;

    logic [NUM_LINES-1:0] lvl_now, lvl_prev;
    logic [NB-1:0]        hit, trig_q, mask_q, pend_q;

    gsvc_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .now_q  (lvl_now),
        .prev_q (lvl_prev)
    );

    // Each line reads the trigger field shared by its aligned group of four.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign hit[i] = line_hit(trig_q[4*(i/4) +: 4], lvl_now[i], lvl_prev[i]);
    end
    if (NB > NUM_LINES) begin : g_pad
        assign hit[NB-1:NUM_LINES] = '0;
    end

    gsvc_regs #(.NWORDS(NWORDS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .sel_space (cfg_space),
        .sel_word  (cfg_word),
        .wr_data   (cfg_wdata),
        .hit       (hit),
        .trig_q    (trig_q),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .rd_data   (cfg_rdata)
    );

    gsvc_encode #(.NGRP(NUM_GROUPS), .NB(NB)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend_q),
        .mask    (mask_q),
        .svc     (svc_o),
        .any_act (irq_o)
    );

    AST_IRQ_MATCHES_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (svc_o[7:4] != 4'd0)); // R9

endmodule

// File: tb/gpio_irq_svc_test.sv
// Bench: directed corner cases, then seeded random traffic checked each cycle
// against a model built from the requirements.
module gpio_irq_svc_test;

    localparam int NG = 10;
    localparam int NL = NG * 16;
    localparam int NW = (NG + 1) / 2;
    localparam int NB = NW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] pins = '0;
    logic          we = 1'b0;
    logic [1:0]    spc = 2'd0;
    logic [2:0]    wrd = 3'd0;
    logic [31:0]   wd = '0;
    logic [31:0]   rdata;
    logic          irq;
    logic [7:0]    svc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit cmp_on = 1'b0;

    logic [NL-1:0] m_s1, m_s2, m_s3;
    logic [NB-1:0] m_trig, m_mask, m_pend;

    gpio_irq_svc #(.NUM_GROUPS(NG)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .cfg_we    (we),
        .cfg_space (spc),
        .cfg_word  (wrd),
        .cfg_wdata (wd),
        .cfg_rdata (rdata),
        .irq_o     (irq),
        .svc_o     (svc)
    );

    always #4 clk = ~clk;

    function automatic logic exp_hit(input logic [3:0] c, input logic now, input logic prev);
        if (c == 4'd0) return !now;
        if (c == 4'd1) return now;
        if (c == 4'd2) return prev & !now;
        if (c == 4'd4) return now & !prev;
        if (c == 4'd6) return now ^ prev;
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_svc();
        for (int i = 0; i < NL; i++)
            if (m_pend[i] && !m_mask[i]) return {4'(i / 16 + 1), 4'(i % 16)};
        return 8'd0;
    endfunction

    function automatic logic [31:0] exp_rd();
        if (int'(wrd) >= NW) return 32'd0;
        case (spc)
            2'd0: return m_trig[int'(wrd)*32 +: 32];
            2'd1: return m_mask[int'(wrd)*32 +: 32];
            2'd2: return m_pend[int'(wrd)*32 +: 32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] rnd_trig();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            case ($urandom % 8)
                0: v[4*k +: 4] = 4'd0;
                1: v[4*k +: 4] = 4'd1;
                2: v[4*k +: 4] = 4'd2;
                3: v[4*k +: 4] = 4'd6;
                default: v[4*k +: 4] = 4'd4;
            endcase
        end
        return v;
    endfunction

    // Model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin : mdl
        logic [NB-1:0] h, clr;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0;
            m_trig = {NW*8{4'h4}};
            m_mask = '1;
            m_pend = '0;
        end else begin
            h = '0;
            for (int i = 0; i < NL; i++) h[i] = exp_hit(m_trig[4*(i/4) +: 4], m_s2[i], m_s3[i]);
            clr = '0;
            if (we && spc == 2'd2 && int'(wrd) < NW) clr[int'(wrd)*32 +: 32] = wd;
            m_pend = (m_pend & ~clr) | h;
            if (we && spc == 2'd0 && int'(wrd) < NW) m_trig[int'(wrd)*32 +: 32] = wd;
            if (we && spc == 2'd1 && int'(wrd) < NW) m_mask[int'(wrd)*32 +: 32] = wd;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R8 svc_o vs model", {24'd0, svc}, {24'd0, exp_svc()});
            chk("R9 irq_o vs model", {31'd0, irq}, {31'd0, exp_svc() != 8'd0});
            chk("R2 cfg_rdata vs model", rdata, exp_rd());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] w, input logic [31:0] d);
        @(negedge clk); #1;
        we = 1'b1; spc = s; wrd = w; wd = d;
        @(negedge clk); #1;
        we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        idle(3);
        // R1: reset state across all three spaces and both outputs
        spc = 2'd1; wrd = 3'd0; #1;
        chk("R1 mask reset", rdata, 32'hFFFF_FFFF);
        spc = 2'd2; #1;
        chk("R1 pending reset", rdata, 32'd0);
        spc = 2'd0; #1;
        chk("R1 trigger reset", rdata, 32'h4444_4444);
        chk("R1 svc reset", {24'd0, svc}, 32'd0);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        for (int w = 0; w < NW; w++) wr(2'd1, 3'(w), 32'd0);

        // R3 and R7: rising edge on line 37 shows up on the third edge as group 3 pin 5
        pins[37] = 1'b1;
        idle(2);
        chk("R3 not yet after two edges", {24'd0, svc}, 32'd0);
        idle(1);
        chk("R7 line 37 code", {24'd0, svc}, 32'h35);

        // R8: lower group wins, then lower pin within group
        pins[25] = 1'b1; pins[20] = 1'b1;
        idle(3);
        chk("R8 lowest pin in lowest group", {24'd0, svc}, 32'h24);
        wr(2'd2, 3'd0, 32'h0010_0000);
        chk("R8 after clearing line 20", {24'd0, svc}, 32'h29);
        wr(2'd2, 3'd0, 32'h0200_0000);
        chk("R8 after clearing line 25", {24'd0, svc}, 32'h35);

        // R4: a masked line keeps its pending bit but leaves the outputs idle
        wr(2'd1, 3'd1, 32'h0000_0020);
        chk("R4 masked svc", {24'd0, svc}, 32'd0);
        chk("R4 masked irq", {31'd0, irq}, 32'd0);
        spc = 2'd2; wrd = 3'd1; #1;
        chk("R4 pending kept under mask", rdata & 32'h20, 32'h20);
        wr(2'd1, 3'd1, 32'd0);
        chk("R4 unmasked again", {24'd0, svc}, 32'h35);
        wr(2'd2, 3'd1, 32'h0000_0020);
        chk("R5 cleared line 37", {24'd0, svc}, 32'd0);

        // R10: level-high on line 70 re-latches after a clear while the pin holds
        wr(2'd0, 3'd2, 32'h4444_4414);
        pins[70] = 1'b1;
        idle(3);
        chk("R3 level high line 70", {24'd0, svc}, 32'h56);
        wr(2'd2, 3'd2, 32'h0000_0040);
        chk("R10 level re-latched", {24'd0, svc}, 32'h56);
        pins[70] = 1'b0;
        idle(3);
        wr(2'd2, 3'd2, 32'h0000_0040);
        chk("R10 released level clears", {24'd0, svc}, 32'd0);
        wr(2'd0, 3'd2, 32'h4444_4444);

        // R3: falling code on line 20
        wr(2'd0, 3'd0, 32'h4424_4444);
        pins[20] = 1'b0;
        idle(3);
        chk("R3 falling line 20", {24'd0, svc}, 32'h24);
        wr(2'd2, 3'd0, 32'h0010_0000);
        wr(2'd0, 3'd0, 32'h4444_4444);

        // R6: clear lands on the same edge as the event for line 3
        pins[3] = 1'b1;
        idle(1);
        idle(1);
        we = 1'b1; spc = 2'd2; wrd = 3'd0; wd = 32'h0000_0008;
        idle(1);
        we = 1'b0;
        chk("R6 set beats clear", {24'd0, svc}, 32'h13);
        wr(2'd2, 3'd0, 32'h0000_0008);
        chk("R5 clear after collision", {24'd0, svc}, 32'd0);

        // Seeded random traffic, checked every cycle against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk); #1;
            for (int k = 0; k < 2; k++)
                if ($urandom % 3 == 0) begin
                    int b;
                    b = int'($urandom % NL);
                    pins[b] = ~pins[b];
                end
            we  = ($urandom % 5 == 0);
            spc = 2'($urandom % 3);
            wrd = 3'($urandom % 6);
            case (spc)
                2'd0:    wd = rnd_trig();
                2'd1:    wd = $urandom & $urandom & $urandom;
                default: wd = $urandom;
            endcase
        end
        @(negedge clk); #1;
        we = 1'b0;
        idle(2);
        cmp_on = 1'b0;
        finish_run();
    end

endmodule